// File: doc/BRIEF.md
# Command Mailbox Register Controller

This block is the memory-mapped mailbox through which host software passes commands to a device. The host sees a small register window and a payload buffer, and reaches them with 32-bit or 64-bit accesses. It writes an opcode, a command set and a payload length into the command register and any input data into the payload buffer. It then rings the doorbell. The block presents the command fields to an execution engine over a request/done handshake. When the engine answers, the block stores the return code and drops the doorbell.

A command may not finish at once. In that case the engine returns "background started", and the block then follows that operation on its own. It keeps the background opcode, a 7-bit percent-complete value fed by the engine, and a final return code. While a sanitize operation (background opcode 0x4400) is running, every new doorbell is refused with the busy code. A command whose length is larger than the payload buffer is refused with the invalid-length code. Neither of these refused commands reaches the engine. A single interrupt output gives a one-cycle pulse on foreground completion and on background completion, each under its own enable bit.

Top module: `mbx_ctrl`

## Requirements
- R1: A 32-bit read at offset 0x00 returns the capability word. It holds log2 of the payload size in bits 4:0, a 1 in bit 5 (interrupt supported), a 1 in bit 6 (background interrupt supported) and the message number in bits 10:7. All other bits read as 0.
- R2: The control word at offset 0x04 is cleared by reset. Host writes keep bit 1 (completion interrupt enable) and bit 2 (background interrupt enable). Writing bit 0 as 1 rings the doorbell, which then reads 1 until the command completes.
- R3: A rung command is presented to the engine with exe_cmd = command bits 7:0, exe_set = bits 15:8 and exe_len = bits 35:16 of the 64-bit register at 0x08. exe_req stays high until exe_done. On exe_done, exe_rc goes into bits 47:32 of the status register at 0x10 and the doorbell clears.
- R4: While the doorbell is set, host writes to the command register and to the payload buffer have no effect.
- R5: A command with a length above the payload size in bytes is not presented to the engine. It completes with return code 0x16. A length exactly equal to the payload size is presented to the engine.
- R6: While the background flag is set and the background opcode is 0x4400, a rung command is not presented to the engine. It completes with return code 0x6. Once the background operation ends, commands are presented again.
- R7: When the engine returns 0x1, status bit 0 becomes 1. The background register at 0x18 then shows opcode {set, command} in bits 15:0 and 0 in bits 22:16.
- R8: While the background flag is set, a progress report of 100 or less updates bits 22:16 of the background register, and a report above 100 is ignored. At background completion, bits 22:16 become 100, the background return code goes into bits 47:32 and status bit 0 clears.
- R9: irq gives a one-cycle pulse after a foreground completion when control bit 1 is set, and after a background completion when control bit 2 is set. It stays low when the relevant enable is clear.
- R10: The payload buffer starts at offset 0x20. A 64-bit write fills a whole word. A 32-bit write fills the lower half, or the upper half when address bit 2 is set. Misaligned accesses are ignored. The buffer can be read by the host and, through exe_pl_idx/exe_pl_data, by the engine.
- R11: The status register (0x10) and the background register (0x18) cannot be written by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is returned one cycle later |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wdata | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| bus_rdata | output | 64 | Read data; a 32-bit read returns in bits 31:0 |
| exe_req | output | 1 | Command presented to the engine |
| exe_cmd | output | 8 | Command opcode |
| exe_set | output | 8 | Command set |
| exe_len | output | 20 | Payload length in bytes |
| exe_done | input | 1 | Engine finished the presented command |
| exe_rc | input | 16 | Engine return code |
| exe_pl_idx | input | IDX_W | Payload word index read by the engine |
| exe_pl_data | output | 64 | Payload word at exe_pl_idx |
| bg_pct_valid | input | 1 | Background progress report strobe |
| bg_pct | input | 7 | Reported percent complete |
| bg_done | input | 1 | Background operation finished |
| bg_rc | input | 16 | Background return code |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench runs the command path with a normal command, with a command that returns an error code, and with a command whose length sits exactly at the payload limit and one byte beyond it. This separates forwarding from immediate refusal. A long engine delay keeps the doorbell up, so writes made during that window must leave the command register and the payload unchanged. A sanitize started in the background is driven with legal and out-of-range progress reports, and a command is rung while it runs. This separates refusal for a busy device from refusal for a bad length, and checks that commands flow again once the background operation ends.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [15:0] RC_SUCCESS    = 16'h0000;
  localparam logic [15:0] RC_BG_STARTED = 16'h0001;
  localparam logic [15:0] RC_BAD_INPUT  = 16'h0002;
  localparam logic [15:0] RC_UNSUPP     = 16'h0003;
  localparam logic [15:0] RC_INTERNAL   = 16'h0004;
  localparam logic [15:0] RC_RETRY      = 16'h0005;
  localparam logic [15:0] RC_BUSY       = 16'h0006;
  localparam logic [15:0] RC_NO_MEDIA   = 16'h0007;
  localparam logic [15:0] RC_ABORTED    = 16'h0012;
  localparam logic [15:0] RC_BAD_LEN    = 16'h0016;

  localparam logic [15:0] OP_SANITIZE   = 16'h4400;
  localparam logic [6:0]  PCT_FULL      = 7'd100;

  // Merge a 32- or 64-bit write into a 64-bit word.
  function automatic logic [63:0] lane_merge(input logic [63:0] old_w,
                                             input logic [63:0] wd,
                                             input logic        wide,
                                             input logic        hi);
    if (wide)    return wd;
    else if (hi) return {wd[31:0], old_w[31:0]};
    else         return {old_w[63:32], wd[31:0]};
  endfunction

  // Capability word: size exponent, two support flags, message number.
  function automatic logic [31:0] cap_word(input logic [4:0] shift,
                                           input logic [3:0] msg);
    return {21'd0, msg, 1'b1, 1'b1, shift};
  endfunction

  // Length fits the payload buffer.
  function automatic logic len_fits(input logic [19:0] len,
                                    input logic [4:0]  shift);
    return len <= (20'd1 << shift);
  endfunction

endpackage

// File: rtl/mbx_payload.sv
module mbx_payload #(
  parameter int WORDS = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wide,
  input  logic             hi,
  input  logic [63:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [63:0]      rdata,
  input  logic [IDX_W-1:0] xidx,
  output logic [63:0]      xdata
);
  import mbx_pkg::*;

  logic [63:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= lane_merge(mem[widx], wdata, wide, hi);
  end

  assign rdata = mem[ridx];
  assign xdata = mem[xidx];

endmodule

// File: rtl/mbx_doorbell_fsm.sv
module mbx_doorbell_fsm #(
  parameter int PL_SHIFT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ring,
  input  logic [19:0] len,
  input  logic        sanitize,
  input  logic        exe_done,
  input  logic [15:0] exe_rc,
  output logic        db,
  output logic        issued,
  output logic        fin,
  output logic        bg_start,
  output logic [15:0] rc_q
);
  import mbx_pkg::*;

  logic        pending;
  logic        len_ok;
  logic        refuse;
  logic        launch;
  logic        answer;
  logic [15:0] fin_rc;

  assign pending  = db & ~issued;
  assign len_ok   = len_fits(len, 5'(PL_SHIFT));
  assign refuse   = pending & (sanitize | ~len_ok);
  assign launch   = pending & ~sanitize & len_ok;
  assign answer   = issued & exe_done;
  assign fin      = refuse | answer;
  assign fin_rc   = issued ? exe_rc : (sanitize ? RC_BUSY : RC_BAD_LEN);
  assign bg_start = answer & (exe_rc == RC_BG_STARTED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db     <= 1'b0;
      issued <= 1'b0;
      rc_q   <= RC_SUCCESS;
    end else begin
      if (ring && !db) db <= 1'b1;
      if (fin) begin
        db   <= 1'b0;
        rc_q <= fin_rc;
      end
      if (launch)      issued <= 1'b1;
      else if (answer) issued <= 1'b0;
    end
  end

endmodule

// File: rtl/mbx_bg_tracker.sv
module mbx_bg_tracker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] start_op,
  input  logic        pct_valid,
  input  logic [6:0]  pct_in,
  input  logic        done,
  input  logic [15:0] done_rc,
  output logic        flag,
  output logic [15:0] op,
  output logic [6:0]  pct,
  output logic [15:0] rc,
  output logic        fin
);
  import mbx_pkg::*;

  assign fin = done & flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      op   <= 16'd0;
      pct  <= 7'd0;
      rc   <= RC_SUCCESS;
    end else begin
      if (fin) begin
        flag <= 1'b0;
        pct  <= PCT_FULL;
        rc   <= done_rc;
      end else if (flag && pct_valid && pct_in <= PCT_FULL) begin
        pct <= pct_in;
      end
      if (start) begin
        flag <= 1'b1;
        op   <= start_op;
        pct  <= 7'd0;
      end
    end
  end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int          PL_SHIFT = 8,
  parameter logic [3:0]  MSG_NUM  = 4'd3,
  localparam int         PL_BYTES = 1 << PL_SHIFT,
  localparam int         PL_WORDS = PL_BYTES / 8,
  localparam int         IDX_W    = PL_SHIFT - 3,
  localparam int         ADDR_W   = PL_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_wide,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              exe_req,
  output logic [7:0]        exe_cmd,
  output logic [7:0]        exe_set,
  output logic [19:0]       exe_len,
  input  logic              exe_done,
  input  logic [15:0]       exe_rc,
  input  logic [IDX_W-1:0]  exe_pl_idx,
  output logic [63:0]       exe_pl_data,
  input  logic              bg_pct_valid,
  input  logic [6:0]        bg_pct,
  input  logic              bg_done,
  input  logic [15:0]       bg_rc,
  output logic              irq
);
  import mbx_pkg::*;

  localparam int QA_W = ADDR_W - 3;

  // Address decode
  logic [QA_W-1:0]  qa;
  logic             hi;
  logic             aligned;
  logic             pl_hit;
  logic [IDX_W-1:0] pl_idx;

  assign qa      = bus_addr[ADDR_W-1:3];
  assign hi      = bus_addr[2];
  assign aligned = (bus_addr[1:0] == 2'b00) && !(bus_wide && hi);
  assign pl_hit  = (qa >= QA_W'(4)) && (qa < QA_W'(4 + PL_WORDS));
  assign pl_idx  = IDX_W'(qa - QA_W'(4));

  // Host-visible state
  logic        int_en, bg_int_en;
  logic [35:0] cmd_q;
  logic        db, ring, fg_fin, bg_start;
  logic [15:0] rc_q;
  logic        bg_flag, bg_fin;
  logic [15:0] bg_op, bg_rc_q;
  logic [6:0]  bg_pct_q;
  logic        sanitize;
  logic [63:0] pl_rdata;

  logic        acc_wr;
  logic        ctrl_touch;
  logic [2:0]  ctrl_bits;
  logic [35:0] cmd_next;

  assign acc_wr     = bus_wr && aligned;
  assign ctrl_touch = acc_wr && (qa == QA_W'(0)) && (bus_wide || hi);
  assign ctrl_bits  = bus_wide ? bus_wdata[34:32] : bus_wdata[2:0];
  assign ring       = ctrl_touch && ctrl_bits[0];
  assign cmd_next   = bus_wide ? bus_wdata[35:0]
                    : (hi ? {bus_wdata[3:0], cmd_q[31:0]}
                          : {cmd_q[35:32], bus_wdata[31:0]});
  assign sanitize   = bg_flag && (bg_op == OP_SANITIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en    <= 1'b0;
      bg_int_en <= 1'b0;
      cmd_q     <= 36'd0;
    end else begin
      if (ctrl_touch) begin
        int_en    <= ctrl_bits[1];
        bg_int_en <= ctrl_bits[2];
      end
      if (acc_wr && qa == QA_W'(1) && !db) cmd_q <= cmd_next;
    end
  end

  mbx_doorbell_fsm #(.PL_SHIFT(PL_SHIFT)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ring     (ring),
    .len      (cmd_q[35:16]),
    .sanitize (sanitize),
    .exe_done (exe_done),
    .exe_rc   (exe_rc),
    .db       (db),
    .issued   (exe_req),
    .fin      (fg_fin),
    .bg_start (bg_start),
    .rc_q     (rc_q)
  );

  mbx_bg_tracker u_bg (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (bg_start),
    .start_op  (cmd_q[15:0]),
    .pct_valid (bg_pct_valid),
    .pct_in    (bg_pct),
    .done      (bg_done),
    .done_rc   (bg_rc),
    .flag      (bg_flag),
    .op        (bg_op),
    .pct       (bg_pct_q),
    .rc        (bg_rc_q),
    .fin       (bg_fin)
  );

  mbx_payload #(.WORDS(PL_WORDS), .IDX_W(IDX_W)) u_pl (
    .clk   (clk),
    .we    (acc_wr && pl_hit && !db),
    .widx  (pl_idx),
    .wide  (bus_wide),
    .hi    (hi),
    .wdata (bus_wdata),
    .ridx  (pl_idx),
    .rdata (pl_rdata),
    .xidx  (exe_pl_idx),
    .xdata (exe_pl_data)
  );

  assign exe_cmd = cmd_q[7:0];
  assign exe_set = cmd_q[15:8];
  assign exe_len = cmd_q[35:16];

  // Read path
  logic [63:0] rd_word;
  always_comb begin
    rd_word = 64'd0;
    if (pl_hit) rd_word = pl_rdata;
    else begin
      case (qa)
        QA_W'(0): rd_word = {29'd0, bg_int_en, int_en, db,
                             cap_word(5'(PL_SHIFT), MSG_NUM)};
        QA_W'(1): rd_word = {28'd0, cmd_q};
        QA_W'(2): rd_word = {16'd0, rc_q, 31'd0, bg_flag};
        QA_W'(3): rd_word = {16'd0, bg_rc_q, 9'd0, bg_pct_q, bg_op};
        default:  rd_word = 64'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 64'd0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) begin
        if (!aligned)     bus_rdata <= 64'd0;
        else if (bus_wide) bus_rdata <= rd_word;
        else              bus_rdata <= {32'd0, hi ? rd_word[63:32] : rd_word[31:0]};
      end
      irq <= (fg_fin && int_en) || (bg_fin && bg_int_en);
    end
  end

endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk #(
  parameter int PL_BYTES = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        db,
  input logic        exe_req,
  input logic        exe_done,
  input logic [19:0] exe_len,
  input logic [35:0] cmd_q,
  input logic        sanitize,
  input logic        fg_fin,
  input logic        bg_fin,
  input logic        bg_start,
  input logic        int_en,
  input logic        bg_int_en,
  input logic        bg_flag,
  input logic [6:0]  bg_pct_q,
  input logic        irq
);

  p_req_needs_db_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |-> db);

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_req && exe_done) |=> (!db && !exe_req));

  p_cmd_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (db && $past(db)) |-> $stable(cmd_q));

  p_len_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |-> (exe_len <= 20'(PL_BYTES)));

  p_no_issue_sanitize_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exe_req) |-> !$past(sanitize));

  p_bg_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bg_start |=> (bg_flag && bg_pct_q == 7'd0));

  p_pct_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bg_pct_q <= 7'd100);

  p_bg_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_fin && !bg_start) |=> (!bg_flag && bg_pct_q == 7'd100));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((fg_fin && int_en) || (bg_fin && bg_int_en)));

endmodule

bind mbx_ctrl mbx_ctrl_chk #(.PL_BYTES(PL_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .db        (db),
  .exe_req   (exe_req),
  .exe_done  (exe_done),
  .exe_len   (exe_len),
  .cmd_q     (cmd_q),
  .sanitize  (sanitize),
  .fg_fin    (fg_fin),
  .bg_fin    (bg_fin),
  .bg_start  (bg_start),
  .int_en    (int_en),
  .bg_int_en (bg_int_en),
  .bg_flag   (bg_flag),
  .bg_pct_q  (bg_pct_q),
  .irq       (irq)
);

// File: tb/mbx_ctrl_bench.sv
module mbx_ctrl_bench;
  localparam int PL_SHIFT = 8;
  localparam int ADDR_W   = PL_SHIFT + 1;
  localparam int IDX_W    = PL_SHIFT - 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0;
  logic [63:0]       bus_wdata = '0;
  logic [63:0]       bus_rdata;
  logic              exe_req;
  logic [7:0]        exe_cmd, exe_set;
  logic [19:0]       exe_len;
  logic              exe_done = 1'b0;
  logic [15:0]       exe_rc = '0;
  logic [IDX_W-1:0]  exe_pl_idx = '0;
  logic [63:0]       exe_pl_data;
  logic              bg_pct_valid = 1'b0;
  logic [6:0]        bg_pct = '0;
  logic              bg_done = 1'b0;
  logic [15:0]       bg_rc = '0;
  logic              irq;

  always #4 clk = ~clk;

  mbx_ctrl #(.PL_SHIFT(PL_SHIFT)) u_mbx_ctrl (.*);

  int n_tests = 0, n_fail = 0;
  logic [63:0] rd_val;
  logic [15:0] resp_rc = '0;
  int          resp_delay = 2;
  int          issued_cnt = 0;
  int          irq_cnt = 0, irq_wide = 0;
  logic        irq_prev = 1'b0;
  logic [35:0] exp_q[$];
  logic [2:0]  ctrl_bits = '0;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d, input logic w);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wide = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic w);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wide = w; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    rd_val = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      rd(4, 1'b0);
      if (rd_val[0] == 1'b0) break;
    end
  endtask

  // Driver: load command, push expectation, ring, wait.
  task automatic run_cmd(input logic [7:0] set, input logic [7:0] cmd,
                         input logic [19:0] len, input bit fwd,
                         input logic [15:0] rc, input int dly);
    resp_rc = rc; resp_delay = dly;
    wr(8, {28'd0, len, set, cmd}, 1'b1);
    if (fwd) exp_q.push_back({len, set, cmd});
    wr(4, {61'd0, ctrl_bits | 3'b001}, 1'b0);
    wait_idle();
  endtask

  task automatic pulse_pct(input logic [6:0] p);
    @(negedge clk); bg_pct = p; bg_pct_valid = 1'b1;
    @(negedge clk); bg_pct_valid = 1'b0;
  endtask

  // Monitor / responder: compares presented commands with the queue.
  initial begin
    forever begin
      @(negedge clk);
      if (exe_req) begin
        issued_cnt++;
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R3: unexpected request %h, expected none", {exe_len, exe_set, exe_cmd});
        end else begin
          check("R3 command fields", {28'd0, exe_len, exe_set, exe_cmd}, {28'd0, exp_q.pop_front()});
        end
        repeat (resp_delay) @(negedge clk);
        exe_rc = resp_rc; exe_done = 1'b1;
        @(negedge clk);
        exe_done = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (irq && irq_prev) irq_wide++;
    irq_prev <= irq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int ic, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd(4, 1'b0);  check("R2 reset ctrl", rd_val, 64'd0);
    rd(16, 1'b1); check("R11 reset status", rd_val, 64'd0);
    rd(24, 1'b1); check("R8 reset bg", rd_val, 64'd0);

    // R1 capability
    rd(0, 1'b0);  check("R1 capability", rd_val, 64'h1E8);

    // R2 enables
    ctrl_bits = 3'b010;
    wr(4, 64'h6, 1'b0);
    rd(4, 1'b0);  check("R2 enables readback", rd_val, 64'h6);
    wr(4, {61'd0, ctrl_bits}, 1'b0);

    // R10 payload lanes
    wr(32, 64'h1111_2222_3333_4444, 1'b1);
    wr(40, 64'hAAAA_BBBB, 1'b0);
    wr(44, 64'hCCCC_DDDD, 1'b0);
    rd(40, 1'b1); check("R10 32-bit lanes", rd_val, 64'hCCCC_DDDD_AAAA_BBBB);
    rd(44, 1'b0); check("R10 32-bit upper read", rd_val, 64'hCCCC_DDDD);
    wr(34, 64'hDEAD, 1'b0);
    rd(32, 1'b1); check("R10 misaligned ignored", rd_val, 64'h1111_2222_3333_4444);
    exe_pl_idx = 1; #1;
    check("R10 engine read", exe_pl_data, 64'hCCCC_DDDD_AAAA_BBBB);

    // R3/R4/R9 long command, writes while busy
    ic = irq_cnt;
    resp_rc = 16'h0; resp_delay = 14;
    wr(8, {28'd0, 20'd16, 8'h01, 8'h02}, 1'b1);
    exp_q.push_back({20'd16, 8'h01, 8'h02});
    wr(4, {61'd0, ctrl_bits | 3'b001}, 1'b0);
    rd(4, 1'b0);  check("R2 doorbell reads set", {63'd0, rd_val[0]}, 64'd1);
    wr(8, 64'hF_FFFF_FFFF, 1'b1);
    wr(32, 64'h0, 1'b1);
    wait_idle();
    rd(8, 1'b1);  check("R4 command kept", rd_val, {28'd0, 20'd16, 8'h01, 8'h02});
    rd(32, 1'b1); check("R4 payload kept", rd_val, 64'h1111_2222_3333_4444);
    rd(16, 1'b1); check("R3 success rc", rd_val, 64'd0);
    check("R9 completion irq", 64'(irq_cnt - ic), 64'd1);

    // R3 error code
    run_cmd(8'h02, 8'h05, 20'd8, 1'b1, 16'h0003, 2);
    rd(16, 1'b1); check("R3 error rc", rd_val, 64'h0000_0003_0000_0000);

    // R5 boundary
    n0 = issued_cnt;
    run_cmd(8'h03, 8'h01, 20'd256, 1'b1, 16'h0, 1);
    check("R5 limit forwarded", 64'(issued_cnt - n0), 64'd1);
    rd(16, 1'b1); check("R5 limit rc", rd_val, 64'd0);
    n0 = issued_cnt;
    run_cmd(8'h03, 8'h01, 20'd257, 1'b0, 16'h0, 1);
    check("R5 over limit not forwarded", 64'(issued_cnt - n0), 64'd0);
    rd(16, 1'b1); check("R5 bad length rc", rd_val, 64'h0000_0016_0000_0000);

    // R7 sanitize background start
    ctrl_bits = 3'b110;
    wr(4, {61'd0, ctrl_bits}, 1'b0);
    run_cmd(8'h44, 8'h00, 20'd0, 1'b1, 16'h0001, 2);
    rd(16, 1'b1); check("R7 bg flag", rd_val, 64'h0000_0001_0000_0001);
    rd(24, 1'b1); check("R7 bg opcode", rd_val, 64'h0000_0000_0000_4400);

    // R8 progress
    pulse_pct(7'd40);
    rd(24, 1'b1); check("R8 progress 40", rd_val, 64'h0000_0000_0028_4400);
    pulse_pct(7'd120);
    rd(24, 1'b1); check("R8 progress >100 ignored", rd_val, 64'h0000_0000_0028_4400);

    // R6 busy while sanitizing
    n0 = issued_cnt;
    run_cmd(8'h01, 8'h02, 20'd4, 1'b0, 16'h0, 1);
    check("R6 not forwarded", 64'(issued_cnt - n0), 64'd0);
    rd(16, 1'b1); check("R6 busy rc", rd_val, 64'h0000_0006_0000_0001);

    // R11 read-only
    wr(16, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    wr(24, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    rd(16, 1'b1); check("R11 status read-only", rd_val, 64'h0000_0006_0000_0001);
    rd(24, 1'b1); check("R11 bg read-only", rd_val, 64'h0000_0000_0028_4400);

    // R8/R9 background completion
    ic = irq_cnt;
    @(negedge clk); bg_rc = 16'h0012; bg_done = 1'b1;
    @(negedge clk); bg_done = 1'b0;
    @(negedge clk);
    check("R9 bg irq", 64'(irq_cnt - ic), 64'd1);
    rd(24, 1'b1); check("R8 bg complete", rd_val, 64'h0000_0012_0064_4400);
    rd(16, 1'b1); check("R8 flag cleared", {63'd0, rd_val[0]}, 64'd0);

    // R6 forwarding resumes, R9 no irq with enables off
    ctrl_bits = 3'b000;
    wr(4, 64'd0, 1'b0);
    ic = irq_cnt; n0 = issued_cnt;
    run_cmd(8'h01, 8'h07, 20'd4, 1'b1, 16'h0, 2);
    check("R6 forwarding resumes", 64'(issued_cnt - n0), 64'd1);
    check("R9 no irq when disabled", 64'(irq_cnt - ic), 64'd0);
    check("R9 pulse width", 64'(irq_wide), 64'd0);
    check("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule